// File: doc/BRIEF.md
# Arithmetic Unit Chooser

The chooser sits in front of the round-robin stage that grants the bus leading to the two arithmetic units. A processor asks for "an arithmetic unit" without naming one. The chooser decides which of the two units it gets and raises a registered request, carrying that unit's index, towards the second stage. It holds that request until the second stage accepts it or the processor gives up.

Each unit reports five things: busy, multi-cycle in progress, attached, malfunction, and the identity of the processor it last served. A processor that is part-way through a multi-cycle sequence always gets its own unit back. A unit that is tied to another processor's sequence is never offered. When both units are held by other processors' sequences, the chooser interrupts unit 0. It keeps that interrupt raised until the unit drops busy, and then offers unit 0.

The states are:
- `CH_IDLE`: evaluates a pending request every cycle and waits while no unit is usable.
- `CH_OFFER`: the request to the second stage is raised.
- `CH_FORCE`: interrupt to unit 0.
- `CH_HOLD`: the request has been accepted, and the chooser waits for the processor to drop its request.

The transitions are:
- IDLE→OFFER when a unit is usable.
- IDLE→FORCE on a double foreign lock.
- OFFER→HOLD on accept.
- OFFER→IDLE on withdrawal, or when the offered unit is granted elsewhere.
- FORCE→IDLE when unit 0 drops busy.
- HOLD→IDLE on withdrawal.

Top module: `au_chooser`

## Requirements
- R1: After reset, `pick_valid` is 0 and both `unit_intr` bits are 0.
- R2: A unit is eligible only when it is attached, free of malfunction, not busy, not granted to another processor, and not in a multi-cycle operation whose last user differs from `req_pid`.
- R3: When both units are eligible, unit 0 (`pick_unit`=0) is offered. Unit 1 (`pick_unit`=1) is offered only when unit 0 is not eligible.
- R4: A unit with multi-cycle in progress whose last user equals `req_pid` is offered, even if it is busy and the other unit is eligible. It must still be attached, fault-free and not granted elsewhere.
- R5: When both units are in multi-cycle operations for other processors, `unit_intr[0]` rises one cycle later. `unit_intr[1]` is never raised, and no request is offered while the interrupt is up.
- R6: `unit_intr[0]` stays high until `unit_busy[0]` is seen low. The chooser then returns to idle and offers unit 0 on the following cycle if it is eligible.
- R7: When only one unit is in another processor's multi-cycle operation, no interrupt is raised and the chooser waits for the other unit.
- R8: When no unit is usable and no interrupt is needed, the chooser waits. It offers whichever unit becomes eligible first, one cycle after that happens.
- R9: A unit flagged in `unit_granted_other` is skipped in favour of the other unit. If it is flagged while it is being offered without acceptance, the offer is dropped on the next cycle and the choice is re-evaluated.
- R10: `pick_valid` and `pick_unit` are registered and hold steady until `stage_accept` or the withdrawal of `req_valid`. After acceptance, no new offer appears until `req_valid` falls. After withdrawal, `pick_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor asks for an arithmetic unit |
| req_pid | input | PID_W | Identity of the requesting processor |
| unit_busy | input | 2 | Per-unit busy |
| unit_multi | input | 2 | Per-unit multi-cycle in progress |
| unit_attached | input | 2 | Per-unit attached and powered |
| unit_fault | input | 2 | Per-unit malfunction |
| unit_last_pid | input | 2*PID_W | Last user of each unit, unit 0 in the low bits |
| unit_granted_other | input | 2 | Unit just given to a different processor |
| stage_accept | input | 1 | Second stage takes the offered request |
| pick_valid | output | 1 | Request towards the second stage |
| pick_unit | output | 1 | Index of the offered unit |
| unit_intr | output | 2 | Interrupt line to each unit |

## Verification
Two of the chooser's functions can meet in one cycle. The first is the affinity rule that hands a processor its own multi-cycle unit. The second is the forced-interrupt rule for the case where both units are locked.

The bench provokes the overlap by marking both units multi-cycle and then changing only `req_pid` between runs:
- When `req_pid` matches a unit's last user, the per-cycle model expects an offer of that unit and a quiet interrupt line.
- When `req_pid` matches neither unit, the model expects `unit_intr[0]` on the next cycle and no offer.

The bench also makes a grant elsewhere coincide with a pending offer, and checks that the offer is withdrawn rather than held.

// File: rtl/au_chooser_pkg.sv
package au_chooser_pkg;
    localparam int AU_COUNT = 2;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_OFFER = 2'd1,
        CH_FORCE = 2'd2,
        CH_HOLD  = 2'd3
    } ch_state_t;
endpackage

// File: rtl/au_unit_class.sv
module au_unit_class #(
    parameter int PID_W = 3
) (
    input  logic             busy,
    input  logic             multi,
    input  logic             attached,
    input  logic             fault,
    input  logic             granted_other,
    input  logic [PID_W-1:0] last_pid,
    input  logic [PID_W-1:0] req_pid,
    output logic             affine_ok,
    output logic             eligible,
    output logic             foreign
);
    logic usable;
    logic own_seq;

    always_comb begin
        usable    = attached && !fault && !granted_other;
        own_seq   = multi && (last_pid == req_pid);
        foreign   = multi && (last_pid != req_pid);
        affine_ok = own_seq && usable;
        eligible  = usable && !busy && !foreign;
    end
endmodule

// File: rtl/au_pick_prio.sv
module au_pick_prio
    import au_chooser_pkg::*;
(
    input  logic [AU_COUNT-1:0] affine_ok,
    input  logic [AU_COUNT-1:0] eligible,
    input  logic [AU_COUNT-1:0] foreign,
    output logic                hit,
    output logic                hit_unit,
    output logic                need_force
);
    always_comb begin
        hit      = 1'b0;
        hit_unit = 1'b0;
        if (affine_ok[0]) begin
            hit = 1'b1;
        end else if (affine_ok[1]) begin
            hit      = 1'b1;
            hit_unit = 1'b1;
        end else if (eligible[0]) begin
            hit = 1'b1;
        end else if (eligible[1]) begin
            hit      = 1'b1;
            hit_unit = 1'b1;
        end
        need_force = !hit && (&foreign);
    end
endmodule

// File: rtl/au_chooser.sv
module au_chooser
    import au_chooser_pkg::*;
#(
    parameter int PID_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [PID_W-1:0]          req_pid,
    input  logic [AU_COUNT-1:0]       unit_busy,
    input  logic [AU_COUNT-1:0]       unit_multi,
    input  logic [AU_COUNT-1:0]       unit_attached,
    input  logic [AU_COUNT-1:0]       unit_fault,
    input  logic [AU_COUNT*PID_W-1:0] unit_last_pid,
    input  logic [AU_COUNT-1:0]       unit_granted_other,
    input  logic                      stage_accept,
    output logic                      pick_valid,
    output logic                      pick_unit,
    output logic [AU_COUNT-1:0]       unit_intr
);
    localparam int FORCE_TARGET = 0;

    logic [AU_COUNT-1:0] affine_ok;
    logic [AU_COUNT-1:0] eligible;
    logic [AU_COUNT-1:0] foreign;
    logic                hit;
    logic                hit_unit;
    logic                need_force;

    ch_state_t state_q, state_d;
    logic      unit_q, unit_d;

    for (genvar u = 0; u < AU_COUNT; u++) begin : g_class
        au_unit_class #(.PID_W(PID_W)) u_class (
            .busy          (unit_busy[u]),
            .multi         (unit_multi[u]),
            .attached      (unit_attached[u]),
            .fault         (unit_fault[u]),
            .granted_other (unit_granted_other[u]),
            .last_pid      (unit_last_pid[u*PID_W +: PID_W]),
            .req_pid       (req_pid),
            .affine_ok     (affine_ok[u]),
            .eligible      (eligible[u]),
            .foreign       (foreign[u])
        );
    end

    au_pick_prio u_prio (
        .affine_ok  (affine_ok),
        .eligible   (eligible),
        .foreign    (foreign),
        .hit        (hit),
        .hit_unit   (hit_unit),
        .need_force (need_force)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unit_d  = unit_q;
        unique case (state_q)
            CH_IDLE: begin
                if (req_valid && hit) begin
                    state_d = CH_OFFER;
                    unit_d  = hit_unit;
                end else if (req_valid && need_force) begin
                    state_d = CH_FORCE;
                end
            end
            CH_OFFER: begin
                if (!req_valid) begin
                    state_d = CH_IDLE;
                end else if (stage_accept) begin
                    state_d = CH_HOLD;
                end else if (unit_granted_other[unit_q]) begin
                    state_d = CH_IDLE;
                end
            end
            CH_FORCE: begin
                if (!unit_busy[FORCE_TARGET]) begin
                    state_d = CH_IDLE;
                end
            end
            CH_HOLD: begin
                if (!req_valid) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            unit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unit_q  <= unit_d;
        end
    end

    // outputs
    always_comb begin
        pick_valid = (state_q == CH_OFFER);
        pick_unit  = unit_q;
        unit_intr  = '0;
        unit_intr[FORCE_TARGET] = (state_q == CH_FORCE);
    end

    AST_INTR_U1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_intr[1]); // R5

    AST_NO_OFFER_DURING_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        !(pick_valid && unit_intr[0])); // R5

    AST_INTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        unit_intr[0] && unit_busy[0] |=> unit_intr[0]); // R6

    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid && req_valid && !stage_accept && !unit_granted_other[pick_unit]
        |=> pick_valid && $stable(pick_unit)); // R10

    AST_WITHDRAW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pick_valid); // R10

    AST_U0_OFFER_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pick_valid) && !pick_unit |-> $past(unit_attached[0] && !unit_fault[0])); // R2
endmodule

// File: tb/au_chooser_test.sv
module au_chooser_test;
    localparam int PID_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [PID_W-1:0] req_pid = '0;
    logic [1:0]       unit_busy = '0;
    logic [1:0]       unit_multi = '0;
    logic [1:0]       unit_attached = 2'b11;
    logic [1:0]       unit_fault = '0;
    logic [2*PID_W-1:0] unit_last_pid = '0;
    logic [1:0]       unit_granted_other = '0;
    logic             stage_accept = 1'b0;
    logic             pick_valid;
    logic             pick_unit;
    logic [1:0]       unit_intr;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string tag = "R1";

    // reference model state
    int m_mode = 0;     // 0 idle, 1 offer, 2 force, 3 hold
    int m_unit = 0;

    au_chooser #(.PID_W(PID_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
        .unit_busy(unit_busy), .unit_multi(unit_multi), .unit_attached(unit_attached),
        .unit_fault(unit_fault), .unit_last_pid(unit_last_pid),
        .unit_granted_other(unit_granted_other), .stage_accept(stage_accept),
        .pick_valid(pick_valid), .pick_unit(pick_unit), .unit_intr(unit_intr)
    );

    always #5 clk = ~clk;

    function automatic int last_of(int u);
        return int'(unit_last_pid[u*PID_W +: PID_W]);
    endfunction

    // -1 none, 0/1 unit, 2 forced interrupt
    function automatic int choose();
        int locked_other = 0;
        for (int u = 0; u < 2; u++)
            if (unit_multi[u] && last_of(u) == int'(req_pid) && unit_attached[u]
                && !unit_fault[u] && !unit_granted_other[u]) return u;
        for (int u = 0; u < 2; u++) begin
            bit other_seq = unit_multi[u] && last_of(u) != int'(req_pid);
            if (!unit_busy[u] && unit_attached[u] && !unit_fault[u]
                && !unit_granted_other[u] && !other_seq) return u;
        end
        for (int u = 0; u < 2; u++)
            if (unit_multi[u] && last_of(u) != int'(req_pid)) locked_other++;
        return (locked_other == 2) ? 2 : -1;
    endfunction

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: update the model at the edge, compare away from it
    task automatic step();
        int c;
        @(posedge clk);
        if (!rst_n) m_mode = 0;
        else begin
            case (m_mode)
                0: if (req_valid) begin
                       c = choose();
                       if (c == 0 || c == 1) begin m_mode = 1; m_unit = c; end
                       else if (c == 2) m_mode = 2;
                   end
                1: if (!req_valid) m_mode = 0;
                   else if (stage_accept) m_mode = 3;
                   else if (unit_granted_other[m_unit]) m_mode = 0;
                2: if (!unit_busy[0]) m_mode = 0;
                default: if (!req_valid) m_mode = 0;
            endcase
        end
        @(negedge clk);
        check("pick_valid", int'(pick_valid), int'(m_mode == 1));
        if (m_mode == 1) check("pick_unit", int'(pick_unit), m_unit);
        check("unit_intr", int'(unit_intr), (m_mode == 2) ? 1 : 0);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic quiet();
        req_valid = 0; stage_accept = 0; unit_busy = 0; unit_multi = 0;
        unit_attached = 2'b11; unit_fault = 0; unit_granted_other = 0;
        steps(2);
    endtask

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        steps(3);
        rst_n = 1;
        tag = "R1";
        step();
        check("R1 reset offer", int'(pick_valid), 0);
        check("R1 reset intr", int'(unit_intr), 0);

        tag = "R3";
        req_pid = 3'd2; req_valid = 1;
        step();
        check("R3 prefers unit 0", int'(pick_unit), 0);
        stage_accept = 1; step(); stage_accept = 0;
        steps(2);
        check("R10 no offer after accept", int'(pick_valid), 0);
        quiet();

        tag = "R2";
        unit_fault = 2'b01; req_valid = 1; step();
        check("R2 fault skips unit 0", int'(pick_unit), 1);
        quiet();
        unit_attached = 2'b10; req_valid = 1; step();
        check("R2 detached skips unit 0", int'(pick_unit), 1);
        quiet();
        unit_busy = 2'b01; req_valid = 1; step();
        check("R2 busy skips unit 0", int'(pick_unit), 1);
        quiet();

        tag = "R4";
        req_pid = 3'd4; unit_last_pid = {3'd4, 3'd1};
        unit_multi = 2'b10; unit_busy = 2'b10; req_valid = 1; step();
        check("R4 affinity unit 1", int'(pick_unit), 1);
        check("R4 affinity offered", int'(pick_valid), 1);
        quiet();

        tag = "R5";
        req_pid = 3'd5; unit_last_pid = {3'd2, 3'd1};
        unit_multi = 2'b11; unit_busy = 2'b11; req_valid = 1; step();
        check("R5 intr unit 0", int'(unit_intr), 1);
        tag = "R6";
        steps(3);
        unit_multi = 2'b10; steps(2);
        check("R6 intr held while busy", int'(unit_intr), 1);
        unit_busy = 2'b10; step(); step();
        check("R6 unit 0 offered after clear", int'(pick_valid), 1);
        check("R6 unit 0 index", int'(pick_unit), 0);
        quiet();

        tag = "R7";
        unit_last_pid = {3'd0, 3'd1}; req_pid = 3'd3;
        unit_multi = 2'b01; unit_busy = 2'b11; req_valid = 1; steps(3);
        check("R7 no intr single lock", int'(unit_intr), 0);
        unit_busy = 2'b01; step();
        check("R7 other unit taken", int'(pick_unit), 1);
        quiet();

        tag = "R8";
        unit_busy = 2'b11; req_valid = 1; steps(3);
        check("R8 waits", int'(pick_valid), 0);
        unit_busy = 2'b01; step();
        check("R8 first cleared", int'(pick_unit), 1);
        quiet();

        tag = "R9";
        unit_granted_other = 2'b01; req_valid = 1; step();
        check("R9 skips granted unit", int'(pick_unit), 1);
        unit_granted_other = 2'b11; step();
        check("R9 offer dropped", int'(pick_valid), 0);
        unit_granted_other = 2'b00; steps(2);
        quiet();

        tag = "R10";
        req_valid = 1; steps(4);
        check("R10 offer held", int'(pick_valid), 1);
        req_valid = 0; step();
        check("R10 withdraw", int'(pick_valid), 0);
        quiet();

        tag = "R5";
        req_pid = 3'd1; unit_last_pid = {3'd2, 3'd1};
        unit_multi = 2'b11; unit_busy = 2'b11; req_valid = 1; step();
        check("R5 affinity beats force", int'(unit_intr), 0);
        quiet();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule